// File: doc/BRIEF.md
# PLL Start-up Sequencing Controller

This block brings a clock multiplier online under software control while keeping that control tamper-resistant. Software stages a configuration word, an enable request and a connect request through a small write port. None of them reaches the outputs until a two-write key sequence is written to the feed address. Each such sequence releases exactly one staged action. Priority runs from configuration to enable to connect, so an update and an enable can never land together.

After the multiplier is enabled, the block decides when its output may be trusted. The reference frequency is the input frequency divided by the pre-divider taken from the committed configuration. When that frequency lies inside the range where the lock flag is dependable, readiness follows the lock input. When it lies outside that range, the lock input is ignored and a start-up timeout is used. Above the range the timeout is 500 µs, counted in block clock cycles. Below the range it is 200 reference-clock pulses. A connect request is honoured only if three conditions hold: the multiplier is enabled, readiness has been reached, and the CPU clock divider was written since the last enable commit. Readiness may raise an interrupt.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset, `pll_en`, `pll_con`, `lock_ready` and `irq` are 0 and `pll_cfg` is 0x0000.
- R2: Two bus writes to address 2 commit one staged action: first data 0x00AA, then data 0x0055, with no other write between them. Idle cycles may separate the two writes. The committed effect appears at the outputs after the clock edge that samples the 0x0055 write.
- R3: Any other write between the 0x00AA and 0x0055 keys aborts the sequence. Nothing is committed, and every staged action stays staged for a later sequence.
- R4: Each complete sequence commits at most one staged action. A staged configuration goes first, then a staged enable change, then a staged connect change.
- R5: A write to address 0 stages the configuration word. Bits [15:8] are the pre-divider minus one and bits [7:0] are the multiplier. A write to address 1 stages the enable value (bit 0) and the connect value (bit 1). Neither write changes `pll_en`, `pll_con` or `pll_cfg` until it is committed.
- R6: A committed connect request sets `pll_con` only if three conditions hold: `pll_en` is 1, `lock_ready` is 1, and address 3 (the CPU divider) was written while enabled and not connected, after the most recent enable commit. Otherwise the request is consumed and `pll_con` stays 0.
- R7: Committing enable = 0 clears `pll_en`, `pll_con` and `lock_ready` together, after that same clock edge.
- R8: When the reference frequency is at least 100 kHz and at most 20,000 kHz, `lock_ready` equals `pll_en` AND `pll_lock`.
- R9: When the reference frequency is above 20,000 kHz, `pll_lock` is ignored. `lock_ready` rises exactly 500×TICKS_PER_US clock cycles after the edge that commits the enable.
- R10: When the reference frequency is below 100 kHz, `pll_lock` is ignored. `lock_ready` rises after the edge that samples the 200th `ref_tick` pulse following the enable commit.
- R11: `irq` equals `lock_ready` AND the interrupt-enable bit (address 1, bit 2). That bit takes effect on the write itself, without a key sequence.
- R12: Committing a configuration while enabled restarts the start-up timeout and clears a timeout-based `lock_ready` after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the fixed-rate timeout clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| wr_addr | input | 2 | 0 config, 1 control, 2 feed key, 3 CPU divider |
| wr_data | input | 16 | Write data |
| pll_lock | input | 1 | Behavioural lock indication from the multiplier |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| pll_en | output | 1 | Multiplier enable |
| pll_con | output | 1 | Multiplier output selected as system clock |
| pll_cfg | output | 16 | Committed configuration word |
| lock_ready | output | 1 | Output is stable and may be connected |
| irq | output | 1 | Readiness interrupt |

## Verification
A wrong key-sequence state shows up at the ports on the very next 0x0055 write, as a commit that should not happen or a missing one. A corrupted staging flag shows up the same way: the wrong action lands, or two actions land where one was expected. An error in the timeout counter or in the mode decision is visible only when `lock_ready` rises. The bench therefore samples one cycle or one tick before the exact rise point and again at it, and tests the reference-range boundaries at 100 kHz and above 20 MHz. A stale divider-written flag shows up as a connect accepted after a fresh enable.

// File: rtl/pll_seq_pkg.sv
// Package: shared address map, feed keys and state types for the
// PLL start-up sequencer. Assumes a 2-bit word address and 16-bit data.
package pll_seq_pkg;
    localparam logic [1:0] ADDR_CFG  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_FEED = 2'd2;
    localparam logic [1:0] ADDR_DIV  = 2'd3;

    localparam logic [15:0] KEY_FIRST  = 16'h00AA;
    localparam logic [15:0] KEY_SECOND = 16'h0055;

    typedef enum logic [0:0] {
        FEED_IDLE  = 1'b0,
        FEED_ARMED = 1'b1
    } feed_state_e;

    typedef struct packed {
        logic cfg;
        logic en;
        logic con;
    } commit_sel_t;
endpackage

// File: rtl/pll_feed_guard.sv
// Module: key-sequence detector. Raises feed_ok for the single cycle in which
// the second key is written directly after the first key, counting only bus
// writes (idle cycles do not break the sequence).
// Assumes one write per asserted wr_en cycle.
module pll_feed_guard
    import pll_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [15:0] wr_data,
    output logic        feed_ok
);
    feed_state_e st_q;
    logic        is_first;
    logic        is_second;

    // Decode the two key writes.
    always_comb begin
        is_first  = wr_en && (wr_addr == ADDR_FEED) && (wr_data == KEY_FIRST);
        is_second = wr_en && (wr_addr == ADDR_FEED) && (wr_data == KEY_SECOND);
    end

    // Release strobe: second key while armed.
    always_comb feed_ok = is_second && (st_q == FEED_ARMED);

    // Arm on the first key; any other write disarms (a repeated first key re-arms).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= FEED_IDLE;
        end else if (wr_en) begin
            st_q <= is_first ? FEED_ARMED : FEED_IDLE;
        end
    end

    // R2: the armed state is only ever entered through a first-key write.
    p_arm_by_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == FEED_ARMED) |-> $past(wr_en && wr_addr == ADDR_FEED && wr_data == KEY_FIRST));

    // R3: a non-key write while armed always drops the arm.
    p_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FEED_ARMED && wr_en && !(wr_addr == ADDR_FEED && (wr_data == KEY_FIRST || wr_data == KEY_SECOND)))
        |=> (st_q == FEED_IDLE));
endmodule

// File: rtl/pll_startup_timer.sv
// Module: decides when the multiplier output may be trusted. Classifies the
// reference frequency (IN_KHZ / (pre-divider + 1)) against the lock-flag
// trust range, then either follows the lock input or runs a timeout:
// 500 us of block clock above the range, 200 reference ticks below it.
// Assumes the block clock runs at TICKS_PER_US cycles per microsecond.
module pll_startup_timer #(
    parameter int unsigned IN_KHZ       = 24000,
    parameter int unsigned TICKS_PER_US = 4,
    parameter int unsigned PDIV_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [PDIV_W-1:0] pdiv,
    input  logic              pll_lock,
    input  logic              ref_tick,
    output logic              ready
);
    localparam int unsigned LONG_CYC = 500 * TICKS_PER_US;
    localparam int unsigned SLOW_CYC = 200;
    localparam int unsigned CNT_MAX  = (LONG_CYC > SLOW_CYC) ? LONG_CYC : SLOW_CYC;
    localparam int unsigned CW       = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] LONG_LAST = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_CYC - 1);

    logic [31:0]   div_n;
    logic          ref_low;
    logic          ref_high;
    logic          trusted;
    logic          tick;
    logic [CW-1:0] last;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    // Reference-range classification without a divider.
    always_comb begin
        div_n    = 32'(pdiv) + 32'd1;
        ref_low  = IN_KHZ < (32'd100 * div_n);
        ref_high = IN_KHZ > (32'd20000 * div_n);
        trusted  = !ref_low && !ref_high;
    end

    // Timeout source and length for the untrusted modes.
    always_comb begin
        tick = ref_high ? 1'b1 : ref_tick;
        last = ref_high ? LONG_LAST : SLOW_LAST;
    end

    // Timeout counter: cleared when stopped or restarted, latches done.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q && tick) begin
            if (cnt_q == last) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Readiness: lock flag inside the trust range, timeout outside it.
    always_comb ready = run && (trusted ? pll_lock : done_q);

    // R9/R10: done only rises after the full count for the active mode.
    p_timeout_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> ($past(cnt_q) == $past(last)));

    // R12: a restart always leaves the timeout not done.
    p_restart_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done_q);
endmodule

// File: rtl/pll_seq_ctrl.sv
// Module: top of the PLL start-up sequencer. Stages configuration, enable
// and connect requests from the write port, releases one per completed key
// sequence (configuration, then enable, then connect), checks that the CPU
// divider was reprogrammed between enable and connect, and reports readiness
// with an optional interrupt.
// Assumes a single-cycle write strobe and a synchronous lock input.
module pll_seq_ctrl
    import pll_seq_pkg::*;
#(
    parameter int unsigned IN_KHZ       = 24000,
    parameter int unsigned TICKS_PER_US = 4,
    parameter int unsigned DATA_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pll_lock,
    input  logic              ref_tick,
    output logic              pll_en,
    output logic              pll_con,
    output logic [DATA_W-1:0] pll_cfg,
    output logic              lock_ready,
    output logic              irq
);
    localparam int unsigned PDIV_W = DATA_W / 2;

    logic              feed_ok;
    logic              t_ready;
    logic              ready_w;
    commit_sel_t       sel;
    logic [DATA_W-1:0] cfg_stage_q;
    logic              pend_cfg_q;
    logic              pend_en_q;
    logic              pend_en_val_q;
    logic              pend_con_q;
    logic              pend_con_val_q;
    logic              irq_en_q;
    logic              div_ok_q;
    logic              wr_cfg;
    logic              wr_ctrl;
    logic              wr_div;
    logic              restart;

    pll_feed_guard u_feed (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .feed_ok (feed_ok)
    );

    // Write decode for the staging registers.
    always_comb begin
        wr_cfg  = wr_en && (wr_addr == ADDR_CFG);
        wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
        wr_div  = wr_en && (wr_addr == ADDR_DIV);
    end

    // One-per-feed selection in fixed priority order.
    always_comb begin
        sel.cfg = feed_ok && pend_cfg_q;
        sel.en  = feed_ok && !pend_cfg_q && pend_en_q;
        sel.con = feed_ok && !pend_cfg_q && !pend_en_q && pend_con_q;
    end

    // Timer restart on enable-on or on a configuration commit.
    always_comb restart = (sel.en && pend_en_val_q) || sel.cfg;

    pll_startup_timer #(
        .IN_KHZ       (IN_KHZ),
        .TICKS_PER_US (TICKS_PER_US),
        .PDIV_W       (PDIV_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pll_en),
        .restart  (restart),
        .pdiv     (pll_cfg[DATA_W-1 -: PDIV_W]),
        .pll_lock (pll_lock),
        .ref_tick (ref_tick),
        .ready    (t_ready)
    );

    // Readiness is gated by the enable register so disable clears it at once.
    always_comb begin
        ready_w    = pll_en && t_ready;
        lock_ready = ready_w;
        irq        = ready_w && irq_en_q;
    end

    // Staging of configuration and requests; commit consumes the chosen one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_stage_q    <= '0;
            pend_cfg_q     <= 1'b0;
            pend_en_q      <= 1'b0;
            pend_en_val_q  <= 1'b0;
            pend_con_q     <= 1'b0;
            pend_con_val_q <= 1'b0;
            irq_en_q       <= 1'b0;
        end else begin
            if (wr_cfg) begin
                cfg_stage_q <= wr_data;
                pend_cfg_q  <= 1'b1;
            end else if (sel.cfg) begin
                pend_cfg_q  <= 1'b0;
            end
            if (wr_ctrl) begin
                pend_en_q      <= (wr_data[0] != pll_en);
                pend_en_val_q  <= wr_data[0];
                pend_con_q     <= (wr_data[1] != pll_con);
                pend_con_val_q <= wr_data[1];
                irq_en_q       <= wr_data[2];
            end else begin
                if (sel.en)  pend_en_q  <= 1'b0;
                if (sel.con) pend_con_q <= 1'b0;
            end
        end
    end

    // Committed configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_cfg <= '0;
        end else if (sel.cfg) begin
            pll_cfg <= cfg_stage_q;
        end
    end

    // Enable, connect and divider-window tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pll_en   <= 1'b0;
            pll_con  <= 1'b0;
            div_ok_q <= 1'b0;
        end else if (sel.en) begin
            pll_en   <= pend_en_val_q;
            div_ok_q <= 1'b0;
            if (!pend_en_val_q) pll_con <= 1'b0;
        end else if (sel.con) begin
            if (!pend_con_val_q)
                pll_con <= 1'b0;
            else if (pll_en && ready_w && div_ok_q)
                pll_con <= 1'b1;
        end else if (wr_div && pll_en && !pll_con) begin
            div_ok_q <= 1'b1;
        end
    end

    // R4: never more than one action released per sequence.
    p_one_action_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel.cfg, sel.en, sel.con}));

    // R6: connect only rises when readiness and the divider window held.
    p_con_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_con) |-> $past(ready_w && div_ok_q && pll_en));

    // R7: a disable commit drops enable, connect and readiness together.
    p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.en && !pend_en_val_q) |=> (!pll_en && !pll_con && !lock_ready));

    // R7: connect is never held without enable.
    p_con_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pll_con |-> pll_en);

    // R5: outputs only move on a commit.
    p_staged_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !feed_ok |=> ($stable(pll_en) && $stable(pll_cfg)));
endmodule

// File: tb/sim_pll_seq_ctrl.sv
module sim_pll_seq_ctrl;
    localparam int unsigned TPU   = 4;
    localparam int unsigned LONG  = 500 * TPU;
    localparam int unsigned NVEC  = 20;
    localparam int unsigned WDOG  = 150000;

    typedef struct packed {
        logic [1:0]  a;
        logic [15:0] d;
        logic        en;
        logic        con;
        logic        rdy;
    } vec_t;

    // Table: write, then expected enable/connect/ready (lock held high, trusted range).
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 16'h0105, 1'b0, 1'b0, 1'b0},  // R5 stage cfg
        '{2'd1, 16'h0003, 1'b0, 1'b0, 1'b0},  // R5 stage en+con
        '{2'd2, 16'h00AA, 1'b0, 1'b0, 1'b0},
        '{2'd2, 16'h0055, 1'b0, 1'b0, 1'b0},  // R4 cfg only
        '{2'd2, 16'h00AA, 1'b0, 1'b0, 1'b0},
        '{2'd2, 16'h0055, 1'b1, 1'b0, 1'b1},  // R4 enable next
        '{2'd2, 16'h00AA, 1'b1, 1'b0, 1'b1},
        '{2'd2, 16'h0055, 1'b1, 1'b0, 1'b1},  // R6 refused, no divider
        '{2'd1, 16'h0003, 1'b1, 1'b0, 1'b1},
        '{2'd3, 16'h0001, 1'b1, 1'b0, 1'b1},
        '{2'd2, 16'h00AA, 1'b1, 1'b0, 1'b1},
        '{2'd2, 16'h0055, 1'b1, 1'b1, 1'b1},  // R6 accepted
        '{2'd2, 16'h00AA, 1'b1, 1'b1, 1'b1},
        '{2'd0, 16'h0105, 1'b1, 1'b1, 1'b1},  // R3 abort
        '{2'd2, 16'h0055, 1'b1, 1'b1, 1'b1},
        '{2'd1, 16'h0000, 1'b1, 1'b1, 1'b1},
        '{2'd2, 16'h00AA, 1'b1, 1'b1, 1'b1},
        '{2'd2, 16'h0055, 1'b1, 1'b1, 1'b1},  // R4 cfg before disable
        '{2'd2, 16'h00AA, 1'b1, 1'b1, 1'b1},
        '{2'd2, 16'h0055, 1'b0, 1'b0, 1'b0}   // R7 disable
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pll_lock = 1'b0;
    logic        ref_tick = 1'b0;
    logic        pll_en, pll_con, lock_ready, irq;
    logic [15:0] pll_cfg;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pll_seq_ctrl #(.IN_KHZ(24000), .TICKS_PER_US(TPU)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pll_lock(pll_lock), .ref_tick(ref_tick),
        .pll_en(pll_en), .pll_con(pll_con), .pll_cfg(pll_cfg),
        .lock_ready(lock_ready), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired: actual %0d cycles expected < %0d", cyc, WDOG);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic feed();
        wr(2'd2, 16'h00AA);
        wr(2'd2, 16'h0055);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pll_lock = 1'b0; ref_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 en", 16'(pll_en), 16'h0);
        chk("R1 con", 16'(pll_con), 16'h0);
        chk("R1 ready", 16'(lock_ready), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);
        chk("R1 cfg", pll_cfg, 16'h0000);

        // Table walk (trusted range, lock high)
        pll_lock = 1'b1;
        for (int i = 0; i < NVEC; i++) begin
            wr(VEC[i].a, VEC[i].d);
            chk($sformatf("R2/R4 vec%0d en", i), 16'(pll_en), 16'(VEC[i].en));
            chk($sformatf("R6/R7 vec%0d con", i), 16'(pll_con), 16'(VEC[i].con));
            chk($sformatf("R8 vec%0d ready", i), 16'(lock_ready), 16'(VEC[i].rdy));
        end
        chk("R5 cfg committed", pll_cfg, 16'h0105);

        // R2 idle cycles between keys; R8 lock follow; R11 irq
        do_reset();
        wr(2'd0, 16'h0100);
        feed();
        wr(2'd1, 16'h0001);
        wr(2'd2, 16'h00AA);
        repeat (5) @(negedge clk);
        wr(2'd2, 16'h0055);
        chk("R2 gap commit", 16'(pll_en), 16'h1);
        chk("R8 no lock", 16'(lock_ready), 16'h0);
        pll_lock = 1'b1; #1;
        chk("R8 lock follows", 16'(lock_ready), 16'h1);
        chk("R11 irq off", 16'(irq), 16'h0);
        wr(2'd1, 16'h0005);
        chk("R11 irq on", 16'(irq), 16'h1);
        chk("R11 no feed needed en", 16'(pll_en), 16'h1);
        pll_lock = 1'b0; #1;
        chk("R8 lock drop", 16'(lock_ready), 16'h0);
        chk("R11 irq drop", 16'(irq), 16'h0);

        // R3 abort keeps staged action
        do_reset();
        wr(2'd1, 16'h0001);
        wr(2'd2, 16'h00AA);
        wr(2'd3, 16'h0001);
        wr(2'd2, 16'h0055);
        chk("R3 abort no commit", 16'(pll_en), 16'h0);
        feed();
        chk("R3 staged kept", 16'(pll_en), 16'h1);

        // R9 fast untrusted mode: pdiv 0 -> 24 MHz reference
        do_reset();
        pll_lock = 1'b1;
        wr(2'd0, 16'h0000);
        feed();
        wr(2'd1, 16'h0001);
        feed();
        repeat (LONG - 1) @(negedge clk);
        chk("R9 before timeout", 16'(lock_ready), 16'h0);
        @(negedge clk);
        chk("R9 at timeout", 16'(lock_ready), 16'h1);
        // R12 config recommit restarts
        wr(2'd0, 16'h0000);
        feed();
        chk("R12 cleared", 16'(lock_ready), 16'h0);
        // R6 refused while not ready even with divider written
        wr(2'd3, 16'h0001);
        wr(2'd1, 16'h0003);
        feed();
        chk("R6 refused not ready", 16'(pll_con), 16'h0);
        repeat (LONG) @(negedge clk);
        chk("R12 ready again", 16'(lock_ready), 16'h1);

        // R10 slow untrusted: pdiv 255 -> 93.75 kHz
        do_reset();
        pll_lock = 1'b1;
        wr(2'd0, 16'hFF00);
        feed();
        wr(2'd1, 16'h0001);
        feed();
        ticks(199);
        chk("R10 before 200 ticks", 16'(lock_ready), 16'h0);
        ticks(1);
        chk("R10 at 200 ticks", 16'(lock_ready), 16'h1);

        // R8 boundary: pdiv 239 -> exactly 100 kHz, trusted
        do_reset();
        pll_lock = 1'b1;
        wr(2'd0, 16'hEF00);
        feed();
        wr(2'd1, 16'h0001);
        feed();
        chk("R8 100kHz trusted", 16'(lock_ready), 16'h1);
        // R10 boundary: pdiv 240 -> below 100 kHz, lock ignored
        do_reset();
        pll_lock = 1'b1;
        wr(2'd0, 16'hF000);
        feed();
        wr(2'd1, 16'h0001);
        feed();
        chk("R10 lock ignored", 16'(lock_ready), 16'h0);

        // R6 divider written before enable does not count
        do_reset();
        pll_lock = 1'b1;
        wr(2'd0, 16'h0100);
        feed();
        wr(2'd3, 16'h0001);
        wr(2'd1, 16'h0003);
        feed();
        feed();
        chk("R6 stale divider", 16'(pll_con), 16'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule